// File: doc/BRIEF.md
# Burst Dimming Stagger Unit

This block takes one burst-dimming reference waveform and produces four per-channel burst-enable outputs. Each output is a copy of the reference high time. Each copy is shifted later by a delay that the channel's own 8-bit stagger code sets. Spreading the bursts of four lamp channels across the dimming cycle in this way lowers the ripple current drawn from the shared supply.

Time is measured in lamp-cycle ticks, which arrive as one-clock strobes on `lamp_tick`. One stagger step is a whole number of lamp ticks, and a 2-bit range select chooses that multiple. The reference is either a locally generated waveform or an external sync input. The external input passes through a two-flop synchronizer.

A burst period starts on each rising edge of the reference. The block measures each period and its high time in lamp ticks, then applies those measurements during the following period. A channel whose delay is longer than the measured period stays off for that whole period.

Top module: `burst_stagger`

## Requirements
- R1: The four channels are independent. Channel i takes its code from `stag_codes[8*i+7:8*i]`, and no code affects another channel's output.
- R2: The delay of a channel is code × M lamp ticks. M is 8 for `range_sel`=00, 4 for 01, 2 for 10 and 1 for 11. A code of zero gives no delay.
- R3: Let k be the number of lamp ticks counted since the current period started, and H the high time of the previous period in lamp ticks. A channel's output is high exactly while delay ≤ k < delay + H.
- R4: A channel whose delay is greater than the measured length of the previous period keeps its output low for the whole current period, even if the current period is long enough to reach that delay. A delay equal to the previous period is not forced off.
- R5: The stagger codes and `range_sel` are sampled when a period starts. A change made during a period only takes effect from the next period.
- R6: After reset all outputs are low. No output goes high before the period that begins at the second rising edge of the reference, that is, before one complete period has been measured.
- R7: With `ext_sel`=1 the reference is `dpwm_ext` after a two-flop synchronizer, and `dpwm_int` has no effect. With `ext_sel`=0 the reference is `dpwm_int`.
- R8: Every rising edge of the reference starts a new period and restarts the tick count. An output pulse still running at that point ends there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| lamp_tick | input | 1 | One-clock strobe per lamp cycle |
| ext_sel | input | 1 | 1 selects the synchronized external reference |
| dpwm_int | input | 1 | Locally generated dimming reference |
| dpwm_ext | input | 1 | External dimming reference, asynchronous |
| range_sel | input | 2 | Step multiple select (00→8, 01→4, 10→2, 11→1) |
| stag_codes | input | 32 | Four 8-bit stagger codes, channel 0 in the low byte |
| burst_en | output | 4 | Per-channel burst enable, bit i for channel i |

## Verification
The bench runs consecutive periods of different lengths. It switches the step multiple between periods so that a design that decodes M with the wrong order or the wrong shift produces shifted pulses. It places a delay exactly equal to the previous period next to one just above it, while the current period is long enough to reach both. A design that compares against the current count instead of the measured period, or that treats "equal" as too long, then lights the wrong channel. Codes are rewritten partway through a period, which exposes a design that uses them before the next period starts. In external-reference periods the local input toggles every tick, so a design that does not ignore it restarts periods and breaks the pattern.

// File: rtl/bst_pkg.sv
package bst_pkg;
  localparam int CODE_W = 8;
  localparam int RNG_W  = 2;
  localparam int MULT_W = 4;

  // Lamp ticks per stagger step for a range select value.
  function automatic logic [MULT_W-1:0] step_mult(input logic [RNG_W-1:0] rng);
    logic [MULT_W-1:0] m;
    case (rng)
      2'b00:   m = 4'd8;
      2'b01:   m = 4'd4;
      2'b10:   m = 4'd2;
      default: m = 4'd1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/bst_ref_sel.sv
module bst_ref_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic dpwm_int,
  input  logic dpwm_ext,
  output logic ref_lvl,
  output logic period_start
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ref_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      ref_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], dpwm_ext};
      ref_prev <= ref_lvl;
    end
  end

  assign ref_lvl      = ext_sel ? sync_q[SYNC_STAGES-1] : dpwm_int;
  assign period_start = ref_lvl & ~ref_prev;

  // R8: a period start is a single-cycle event
  p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);
endmodule

// File: rtl/bst_period_meas.sv
module bst_period_meas #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lamp_tick,
  input  logic             ref_lvl,
  input  logic             period_start,
  output logic [CNT_W-1:0] tick_cnt,
  output logic [CNT_W-1:0] per_len,
  output logic [CNT_W-1:0] hi_len,
  output logic             meas_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] hi_cnt;
  logic             seen_edge;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt   <= '0;
      hi_cnt     <= '0;
      per_len    <= '0;
      hi_len     <= '0;
      seen_edge  <= 1'b0;
      meas_valid <= 1'b0;
    end else if (period_start) begin
      per_len    <= tick_cnt;
      hi_len     <= hi_cnt;
      tick_cnt   <= '0;
      hi_cnt     <= '0;
      seen_edge  <= 1'b1;
      meas_valid <= seen_edge;
    end else if (lamp_tick) begin
      tick_cnt <= sat_inc(tick_cnt);
      if (ref_lvl) hi_cnt <= sat_inc(hi_cnt);
    end
  end

  // R8: the tick count restarts at every period start
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> (tick_cnt == '0));
  // R3: the measured high time never exceeds the measured period
  p_hi_within_r3: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> (hi_len <= per_len));
endmodule

// File: rtl/bst_stagger_ch.sv
module bst_stagger_ch #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     period_start,
  input  logic [bst_pkg::RNG_W-1:0] range_sel,
  input  logic [CODE_W-1:0]        code,
  input  logic [CNT_W-1:0]         tick_cnt,
  input  logic [CNT_W-1:0]         per_len,
  input  logic [CNT_W-1:0]         hi_len,
  input  logic                     meas_valid,
  output logic                     burst_en
);
  logic [CNT_W-1:0] dly_q;
  logic [CNT_W:0]   win_end;
  logic             blank;
  logic             on_next;

  function automatic logic [CNT_W-1:0] delay_of(input logic [CODE_W-1:0] c,
                                                input logic [bst_pkg::RNG_W-1:0] r);
    return CNT_W'(c) * CNT_W'(bst_pkg::step_mult(r));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dly_q <= '0;
    else if (period_start) dly_q <= delay_of(code, range_sel);
  end

  assign blank   = dly_q > per_len;
  assign win_end = {1'b0, dly_q} + {1'b0, hi_len};
  assign on_next = meas_valid && !blank && (tick_cnt >= dly_q)
                   && ({1'b0, tick_cnt} < win_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_en <= 1'b0;
    else        burst_en <= on_next;
  end

  // R4: a delay beyond the measured period keeps the channel dark
  p_blank_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> !burst_en);
  // R3: an output only turns on when the count meets the delay
  p_rise_at_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_en) |-> ($past(tick_cnt) == $past(dly_q)));
  // R6: nothing turns on before a full period has been measured
  p_quiet_until_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> !burst_en);
  // R5: the delay is only reloaded at a period start
  p_delay_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable(dly_q));
endmodule

// File: rtl/burst_stagger.sv
module burst_stagger #(
  parameter int NCH         = 4,
  parameter int CODE_W      = bst_pkg::CODE_W,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lamp_tick,
  input  logic                      ext_sel,
  input  logic                      dpwm_int,
  input  logic                      dpwm_ext,
  input  logic [bst_pkg::RNG_W-1:0] range_sel,
  input  logic [NCH*CODE_W-1:0]     stag_codes,
  output logic [NCH-1:0]            burst_en
);
  logic             ref_lvl;
  logic             period_start;
  logic [CNT_W-1:0] tick_cnt;
  logic [CNT_W-1:0] per_len;
  logic [CNT_W-1:0] hi_len;
  logic             meas_valid;

  bst_ref_sel #(.SYNC_STAGES(SYNC_STAGES)) u_ref (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_sel      (ext_sel),
    .dpwm_int     (dpwm_int),
    .dpwm_ext     (dpwm_ext),
    .ref_lvl      (ref_lvl),
    .period_start (period_start)
  );

  bst_period_meas #(.CNT_W(CNT_W)) u_meas (
    .clk          (clk),
    .rst_n        (rst_n),
    .lamp_tick    (lamp_tick),
    .ref_lvl      (ref_lvl),
    .period_start (period_start),
    .tick_cnt     (tick_cnt),
    .per_len      (per_len),
    .hi_len       (hi_len),
    .meas_valid   (meas_valid)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    bst_stagger_ch #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .period_start (period_start),
      .range_sel    (range_sel),
      .code         (stag_codes[ch*CODE_W +: CODE_W]),
      .tick_cnt     (tick_cnt),
      .per_len      (per_len),
      .hi_len       (hi_len),
      .meas_valid   (meas_valid),
      .burst_en     (burst_en[ch])
    );
  end
endmodule

// File: tb/sim_burst_stagger.sv
module sim_burst_stagger;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lamp_tick = 1'b0;
  logic ext_sel = 1'b0;
  logic dpwm_int = 1'b0;
  logic dpwm_ext = 1'b0;
  logic [1:0] range_sel = 2'b11;
  logic [NCH*8-1:0] stag_codes = '0;
  logic [NCH-1:0] burst_en;

  burst_stagger u0 (
    .clk(clk), .rst_n(rst_n), .lamp_tick(lamp_tick), .ext_sel(ext_sel),
    .dpwm_int(dpwm_int), .dpwm_ext(dpwm_ext), .range_sel(range_sel),
    .stag_codes(stag_codes), .burst_en(burst_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  // scoreboard queues
  logic [NCH-1:0] exp_q[$];
  string          tag_q[$];
  int             slot_q[$];
  event           sample_ev;

  // reference model state
  int m_codes[NCH];
  int m_rng = 3;
  bit have_prev = 1'b0;
  int prev_len = 0;
  int prev_hi = 0;
  bit valid_m = 1'b0;
  int dly_m[NCH];
  bit blank_m[NCH];
  int mid_at = -1;
  int mid_codes[NCH];

  function automatic int mult_of(input int r);
    case (r)
      0: return 8;
      1: return 4;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic drive_codes(input int c0, input int c1, input int c2, input int c3);
    stag_codes = {8'(c3), 8'(c2), 8'(c1), 8'(c0)};
  endtask

  task automatic set_codes(input int c0, input int c1, input int c2, input int c3);
    m_codes[0] = c0; m_codes[1] = c1; m_codes[2] = c2; m_codes[3] = c3;
    drive_codes(c0, c1, c2, c3);
  endtask

  task automatic set_range(input int r);
    m_rng = r;
    range_sel = 2'(r);
  endtask

  task automatic run_slot(input int k, input bit lvl, input string tag);
    logic [NCH-1:0] e;
    @(negedge clk) lamp_tick = 1'b1;
    @(negedge clk) lamp_tick = 1'b0;
    if (ext_sel) begin
      dpwm_ext = lvl;
      dpwm_int = ~dpwm_int;
    end else begin
      dpwm_int = lvl;
    end
    if (k == mid_at) drive_codes(mid_codes[0], mid_codes[1], mid_codes[2], mid_codes[3]);
    repeat (5) @(negedge clk);
    for (int i = 0; i < NCH; i++)
      e[i] = valid_m && !blank_m[i] && (k >= dly_m[i]) && (k < dly_m[i] + prev_hi);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    slot_q.push_back(k);
    -> sample_ev;
  endtask

  task automatic run_period(input int plen, input int hlen, input string tag);
    valid_m = have_prev;
    for (int i = 0; i < NCH; i++) begin
      dly_m[i]   = m_codes[i] * mult_of(m_rng);
      blank_m[i] = dly_m[i] > prev_len;
    end
    for (int k = 0; k < plen; k++) run_slot(k, k < hlen, tag);
    if (mid_at >= 0) begin
      for (int i = 0; i < NCH; i++) m_codes[i] = mid_codes[i];
      mid_at = -1;
    end
    have_prev = 1'b1;
    prev_len  = plen;
    prev_hi   = hlen;
  endtask

  // monitor: pops expected items and compares at the sample point
  initial begin
    forever begin
      logic [NCH-1:0] e;
      string t;
      int s;
      @(sample_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      s = slot_q.pop_front();
      n_checks++;
      if (burst_en !== e) begin
        n_errors++;
        $display("FAIL %s slot %0d: burst_en=%b expected %b", t, s, burst_en, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: run state=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    set_codes(0, 2, 5, 9);
    set_range(3);
    repeat (4) @(negedge clk);
    n_checks++;
    if (burst_en !== '0) begin
      n_errors++;
      $display("FAIL R6 reset: burst_en=%b expected 0000", burst_en);
    end
    rst_n = 1'b1;

    // R6: idle slots and the first, unmeasured period stay dark
    valid_m = 1'b0;
    for (int i = 0; i < NCH; i++) begin dly_m[i] = 0; blank_m[i] = 1'b0; end
    for (int k = 0; k < 3; k++) run_slot(k, 1'b0, "R6");
    run_period(12, 4, "R6");
    // R3 / R8: shifted copies; channel 3 is cut at the next start
    run_period(12, 4, "R3");
    // R2: M=2
    set_range(2); set_codes(0, 1, 3, 4);
    run_period(16, 3, "R2");
    // R4: M=8, delay 16 equals previous period, 24 exceeds it
    set_range(0); set_codes(0, 1, 2, 3);
    run_period(26, 2, "R4");
    // R5: codes rewritten mid-period take effect next period
    set_range(1); set_codes(1, 0, 3, 2);
    mid_at = 2;
    mid_codes[0] = 5; mid_codes[1] = 5; mid_codes[2] = 5; mid_codes[3] = 5;
    run_period(20, 5, "R5");
    run_period(22, 2, "R5");
    // R7: external reference, local input toggling
    set_range(3); set_codes(3, 1, 0, 6);
    @(negedge clk) ext_sel = 1'b1;
    run_period(14, 6, "R7");
    set_codes(11, 0, 2, 4);
    run_period(10, 3, "R8");
    // R1: back to the local reference, independent channels
    @(negedge clk) begin dpwm_int = 1'b0; ext_sel = 1'b0; end
    set_codes(0, 1, 2, 3);
    run_period(10, 4, "R1");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule